// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a RISC integer unit. It has two read ports and one write port. Software always addresses 32 registers. Eight of them are globals that every procedure shares. The other 24 are a view into a larger physical stack of registers. That view moves one position on every procedure entry (save) and moves back on every return (restore). Neighbouring windows overlap by eight registers. The registers a caller fills as its outgoing arguments are therefore the same storage the callee reads as its incoming arguments, so no copy is made.

The number of windows, `NWIN`, is a parameter with a legal range of 3 to 32. The physical store holds 8 globals plus 16 registers per window. A mask input marks some windows as invalid. A save or restore that would enter such a window does not move the pointer. Instead it raises a one-cycle overflow or underflow flag, and the trap logic outside this block spills or fills memory in response. The block has no data stream of its own. Reads are combinational lookups, and writes, saves and restores take effect on each clock edge. All ports are plain control and data pins with no valid/ready handshake, so the block never applies back-pressure.

Top module: `wreg_file`

## Requirements
- R1: Register numbers 1 to 7 are globals. They hold the same storage in every window, and a value written there reads back unchanged after any number of window moves.
- R2: Register number 0 always reads as zero on both read ports. A write to it changes no storage.
- R3: Register numbers 16 to 23 are the locals of the current window. Storage written there in one window is not visible in any other window.
- R4: Register numbers 8 to 15 are the outs of window w, and numbers 24 to 31 are its ins. The ins of window w are the same storage as the outs of window (w+1) mod NWIN.
- R5: A save with no restore in the same cycle sets `cur_win` to (cur_win-1) mod NWIN on the next edge. A restore with no save in the same cycle sets it to (cur_win+1) mod NWIN. Both wrap between 0 and NWIN-1.
- R6: If the target window of a lone save or restore has its bit set in `win_invalid` (bit i marks window i), `cur_win` keeps its value. `move_ovf` (for a save) or `move_unf` (for a restore) is then high for exactly the one cycle after that edge.
- R7: A save and a restore in the same cycle are ignored. `cur_win` does not change and neither flag is raised.
- R8: A read of the same register that is being written in the same cycle returns the new write data on that read port (write-first).
- R9: After reset, `cur_win` is 0, both flags are low and every register reads as zero.
- R10: A write in the same cycle as a save or restore is placed using the window that was current before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_addr | input | 5 | Register number for read port A |
| rd_b_addr | input | 5 | Register number for read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | XLEN | Data to write |
| save_req | input | 1 | Move the window for a procedure entry |
| restore_req | input | 1 | Move the window back for a return |
| win_invalid | input | NWIN | One bit per window; set = window may not be entered |
| rd_a_data | output | XLEN | Data on read port A |
| rd_b_data | output | XLEN | Data on read port B |
| cur_win | output | CWP_W | Current window number |
| move_ovf | output | 1 | A save was blocked by an invalid window (one cycle) |
| move_unf | output | 1 | A restore was blocked by an invalid window (one cycle) |

## Verification
Directed sequences come first. A value is written to an out register and then read back through the ins after a save, which shows that the overlap points the right way rather than the wrong way. A local is written and then read in a neighbouring window, which tells private storage apart from shared storage. Further directed cases cover a write together with a save, a save from window 0 that must wrap, a save and a restore in the same cycle, and a write of register 0. Constrained random traffic then mixes writes to all 32 numbers, reads that often hit the write address and so exercise the bypass, and saves and restores under a random invalid mask. Every read is compared against a reference model of the physical store that the bench maintains.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int ARCH_W    = 5;
  localparam int GROUP_SZ  = 8;
  localparam int NUM_GLOB  = 8;
  localparam int WIN_STRIDE = 2 * GROUP_SZ;

  typedef logic [ARCH_W-1:0] areg_t;

  typedef enum logic [1:0] {
    CLS_GLOBAL = 2'd0,
    CLS_OUT    = 2'd1,
    CLS_LOCAL  = 2'd2,
    CLS_IN     = 2'd3
  } reg_class_e;

  function automatic reg_class_e classify(areg_t a);
    return reg_class_e'(a[4:3]);
  endfunction
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int CWP_W  = 3,
  parameter int PHYS_W = 8
) (
  input  areg_t             arch_i,
  input  logic [CWP_W-1:0]  win_i,
  output logic [PHYS_W-1:0] phys_o
);
  int next_win;
  int idx;

  always_comb begin
    next_win = (int'(win_i) + 1) % NWIN;
    unique case (classify(arch_i))
      CLS_GLOBAL:         idx = int'(arch_i);
      CLS_OUT, CLS_LOCAL: idx = NUM_GLOB + WIN_STRIDE * int'(win_i) + int'(arch_i) - GROUP_SZ;
      default:            idx = NUM_GLOB + WIN_STRIDE * next_win + int'(arch_i) - 3 * GROUP_SZ;
    endcase
    phys_o = PHYS_W'(idx);
  end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int NWIN  = 8,
  parameter int CWP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic [NWIN-1:0]  win_invalid,
  output logic [CWP_W-1:0] cur_win,
  output logic             move_ovf,
  output logic             move_unf
);
  logic [CWP_W-1:0] win_dec, win_inc;

  always_comb begin
    win_dec = (cur_win == '0) ? CWP_W'(NWIN - 1) : cur_win - CWP_W'(1);
    win_inc = (cur_win == CWP_W'(NWIN - 1)) ? '0 : cur_win + CWP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_win  <= '0;
      move_ovf <= 1'b0;
      move_unf <= 1'b0;
    end else begin
      move_ovf <= 1'b0;
      move_unf <= 1'b0;
      if (save_req && !restore_req) begin
        if (win_invalid[win_dec]) move_ovf <= 1'b1;
        else                      cur_win  <= win_dec;
      end else if (restore_req && !save_req) begin
        if (win_invalid[win_inc]) move_unf <= 1'b1;
        else                      cur_win  <= win_inc;
      end
    end
  end
endmodule

// File: rtl/wrf_bank.sv
module wrf_bank #(
  parameter int XLEN   = 32,
  parameter int NPHYS  = 136,
  parameter int PHYS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] rd_phys_a,
  input  logic [PHYS_W-1:0] rd_phys_b,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   rd_a_data,
  output logic [XLEN-1:0]   rd_b_data
);
  logic [XLEN-1:0] store [NPHYS];
  logic            wr_live;

  assign wr_live = wr_en && (wr_phys != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) store[i] <= '0;
    end else if (wr_live) begin
      store[wr_phys] <= wr_data;
    end
  end

  function automatic logic [XLEN-1:0] lookup(logic [PHYS_W-1:0] p);
    if (p == '0)                  return '0;
    if (wr_live && (p == wr_phys)) return wr_data;
    return store[p];
  endfunction

  assign rd_a_data = lookup(rd_phys_a);
  assign rd_b_data = lookup(rd_phys_b);
endmodule

// File: rtl/wreg_file.sv
module wreg_file
  import wrf_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NWIN  = 8,
  localparam int CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int NPHYS  = NUM_GLOB + WIN_STRIDE * NWIN,
  localparam int PHYS_W = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       rd_a_addr,
  input  logic [4:0]       rd_b_addr,
  input  logic             wr_en,
  input  logic [4:0]       wr_addr,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic [NWIN-1:0]  win_invalid,
  output logic [XLEN-1:0]  rd_a_data,
  output logic [XLEN-1:0]  rd_b_data,
  output logic [CWP_W-1:0] cur_win,
  output logic             move_ovf,
  output logic             move_unf
);
  localparam int NPORT = 3;

  areg_t             arch_sel [NPORT];
  logic [PHYS_W-1:0] phys_sel [NPORT];

  assign arch_sel[0] = rd_a_addr;
  assign arch_sel[1] = rd_b_addr;
  assign arch_sel[2] = wr_addr;

  wrf_window_ctl #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .save_req(save_req), .restore_req(restore_req),
    .win_invalid(win_invalid),
    .cur_win(cur_win), .move_ovf(move_ovf), .move_unf(move_unf)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wrf_addr_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map (
      .arch_i(arch_sel[p]), .win_i(cur_win), .phys_o(phys_sel[p])
    );
  end

  wrf_bank #(.XLEN(XLEN), .NPHYS(NPHYS), .PHYS_W(PHYS_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_phys_a(phys_sel[0]), .rd_phys_b(phys_sel[1]),
    .wr_en(wr_en), .wr_phys(phys_sel[2]), .wr_data(wr_data),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
  );
endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
  parameter int XLEN  = 32,
  parameter int NWIN  = 8,
  parameter int CWP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       rd_a_addr,
  input logic [4:0]       rd_b_addr,
  input logic             wr_en,
  input logic [4:0]       wr_addr,
  input logic [XLEN-1:0]  wr_data,
  input logic             save_req,
  input logic             restore_req,
  input logic [NWIN-1:0]  win_invalid,
  input logic [XLEN-1:0]  rd_a_data,
  input logic [XLEN-1:0]  rd_b_data,
  input logic [CWP_W-1:0] cur_win,
  input logic             move_ovf,
  input logic             move_unf
);
  int tgt_down, tgt_up;
  assign tgt_down = (int'(cur_win) + NWIN - 1) % NWIN;
  assign tgt_up   = (int'(cur_win) + 1) % NWIN;

  // R2
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == 5'd0) |-> (rd_a_data == '0));

  // R5
  save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && !win_invalid[tgt_down]) |=> (int'(cur_win) == $past(tgt_down)));

  // R5
  restore_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !win_invalid[tgt_up]) |=> (int'(cur_win) == $past(tgt_up)));

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_ovf |-> ($past(save_req && !restore_req) && $stable(cur_win)));

  // R6
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move_unf |-> ($past(restore_req && !save_req) && $stable(cur_win)));

  // R7
  both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |=> ($stable(cur_win) && !move_ovf && !move_unf));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 5'd0 && rd_b_addr == wr_addr) |-> (rd_b_data == wr_data));

  // R5
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_win) < NWIN);
endmodule

bind wreg_file wrf_chk #(.XLEN(XLEN), .NWIN(NWIN), .CWP_W(CWP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .save_req(save_req), .restore_req(restore_req), .win_invalid(win_invalid),
  .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .cur_win(cur_win),
  .move_ovf(move_ovf), .move_unf(move_unf)
);

// File: tb/wreg_file_test.sv
module wreg_file_test;
  localparam int XLEN  = 32;
  localparam int NWIN  = 8;
  localparam int CWP_W = 3;
  localparam int NPHYS = 8 + 16 * NWIN;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [4:0]       rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic             wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
  logic [XLEN-1:0]  wr_data = '0;
  logic [NWIN-1:0]  win_invalid = '0;
  logic [XLEN-1:0]  rd_a_data, rd_b_data;
  logic [CWP_W-1:0] cur_win;
  logic             move_ovf, move_unf;

  wreg_file #(.XLEN(XLEN), .NWIN(NWIN)) uut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [XLEN-1:0] mdl [NPHYS];
  int mdl_win = 0;

  function automatic int phys(int a, int w);
    if (a < 8)  return a;
    if (a < 24) return 8 + 16 * w + a - 8;
    return 8 + 16 * ((w + 1) % NWIN) + a - 24;
  endfunction

  function automatic string tag_of(int a);
    if (wr_en && a == int'(wr_addr) && a != 0) return "R8";
    if (a == 0) return "R2";
    if (a < 8)  return "R1";
    if (a >= 16 && a < 24) return "R3";
    return "R4";
  endfunction

  function automatic logic [XLEN-1:0] exp_rd(int a);
    int p = phys(a, mdl_win);
    if (p == 0) return '0;
    if (wr_en && phys(int'(wr_addr), mdl_win) == p) return wr_data;
    return mdl[p];
  endfunction

  task automatic check(string tag, string what, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_reads(string force_tag);
    string ta = (force_tag != "") ? force_tag : tag_of(int'(rd_a_addr));
    string tb = (force_tag != "") ? force_tag : tag_of(int'(rd_b_addr));
    check(ta, $sformatf("port A r%0d", rd_a_addr), rd_a_data, exp_rd(int'(rd_a_addr)));
    check(tb, $sformatf("port B r%0d", rd_b_addr), rd_b_data, exp_rd(int'(rd_b_addr)));
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(int ra, int rb, bit we, int wa, logic [XLEN-1:0] wd,
                      bit sv, bit rs, string rtag);
    int tgt;
    bit eo = 0, eu = 0;
    string mt;
    rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
    wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    save_req = sv; restore_req = rs;
    #1 check_reads(rtag);
    // model update from pre-edge state (R10: write uses old window)
    if (we && phys(wa, mdl_win) != 0) mdl[phys(wa, mdl_win)] = wd;
    mt = "R5";
    if (sv && !rs) begin
      tgt = (mdl_win + NWIN - 1) % NWIN;
      if (win_invalid[tgt]) begin eo = 1; mt = "R6"; end else mdl_win = tgt;
    end else if (rs && !sv) begin
      tgt = (mdl_win + 1) % NWIN;
      if (win_invalid[tgt]) begin eu = 1; mt = "R6"; end else mdl_win = tgt;
    end else if (sv && rs) mt = "R7";
    @(posedge clk); #1;
    check(mt, "cur_win", XLEN'(cur_win), XLEN'(mdl_win));
    check((sv && rs) ? "R7" : "R6", "move_ovf", XLEN'(move_ovf), XLEN'(eo));
    check((sv && rs) ? "R7" : "R6", "move_unf", XLEN'(move_unf), XLEN'(eu));
    save_req = 0; restore_req = 0; wr_en = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPHYS; i++) mdl[i] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", "cur_win after reset", XLEN'(cur_win), '0);
    check("R9", "move_ovf after reset", XLEN'(move_ovf), '0);
    check("R9", "move_unf after reset", XLEN'(move_unf), '0);
    for (int a = 0; a < 32; a++) begin
      rd_a_addr = 5'(a); #1;
      check("R9", $sformatf("reset read r%0d", a), rd_a_data, '0);
    end
    // R1, R2, R3, R4 directed
    step(0, 3, 1, 3, 32'h0000_0011, 0, 0, "R1");
    step(0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 8, 32'hAAAA_0008, 0, 0, "");
    step(0, 0, 1, 16, 32'hBBBB_0016, 0, 0, "");
    // R5: save from window 0 wraps to NWIN-1
    step(0, 0, 0, 0, 0, 1, 0, "");
    step(24, 16, 0, 0, 0, 0, 0, "R4");
    step(3, 16, 0, 0, 0, 0, 0, "R3");
    // R10: write with restore uses pre-move window (NWIN-1)
    step(0, 0, 1, 17, 32'hCCCC_0017, 0, 1, "R10");
    step(17, 8, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 0, "");
    step(17, 0, 0, 0, 0, 0, 0, "R10");
    // R8: bypass on both ports
    step(20, 20, 1, 20, 32'h1234_5678, 0, 0, "R8");
    // R6: blocked save and restore
    win_invalid = 8'b0100_0000;
    step(0, 0, 0, 0, 0, 1, 0, "");
    win_invalid = 8'b0000_0001;
    step(0, 0, 0, 0, 0, 0, 1, "");
    // R7: both at once
    win_invalid = '0;
    step(0, 0, 0, 0, 0, 1, 1, "R7");
    step(0, 0, 0, 0, 0, 1, 1, "R7");
    // constrained random
    for (int k = 0; k < 3000; k++) begin
      int wa = $urandom_range(31);
      int ra = ($urandom_range(3) == 0) ? wa : $urandom_range(31);
      int rb = $urandom_range(31);
      int mv = $urandom_range(7);
      if ($urandom_range(15) == 0) begin
        win_invalid = '0;
        for (int b = 0; b < NWIN; b++) win_invalid[b] = ($urandom_range(3) == 0);
      end
      step(ra, rb, $urandom_range(1) == 1, wa, $urandom,
           mv == 1 || mv == 3, mv == 2 || mv == 3, "");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule